// File: doc/BRIEF.md
# UART Transmit-Ready Interrupt Generator

This block decides when a UART should ask the processor for more transmit data. It watches the fill level of the transmit path and the state of the serializer, and it raises one interrupt request. The FIFO storage, the serializer and the line-driver control sit outside the block. Only their status reaches it as inputs.

With the FIFO disabled, the transmit path is a single holding register. The request is raised when that register empties. With the FIFO enabled, the request is raised at two separate moments:

- first, when the fill level drops below a programmed trigger level;
- then, when the FIFO runs empty.

When half-duplex line-driver mode is active, the empty event is held back until the shift register has also finished. Software can then turn the bus around safely.

Each event latches a pending flag. The flag is cleared by a status read that reports this source, or by a byte written into the transmit path. The enable bit only masks the output; it never discards a latched event.

Top module: `uart_txrdy_irq`

## Requirements
- R1: While reset is asserted `irq` is low. After reset the idle, empty transmit path counts as an empty event, so `irq` rises after the first clock edge once `irq_en` is high.
- R2: With `fifo_mode`=0, a `tx_count` of 0 means the holding register is empty. That condition raises the pending request at the next clock edge, and `irq` is high after that edge.
- R3: With `fifo_mode`=1, `tx_count` may fall from at least `trig_level` to below it. The pending request is then set at the next clock edge.
- R4: With `fifo_mode`=1, `tx_count` reaching 0 raises a second, separate event. This holds even when the below-trigger event was already serviced.
- R5: Each event fires once per crossing. The below-trigger event re-arms only when `tx_count` is at or above `trig_level` in FIFO mode. The empty event re-arms only on `tx_write`.
- R6: With `fifo_mode`=1 and `rs485_mode`=1, the empty event waits until `shift_busy` is low. With `fifo_mode`=0, `shift_busy` and `rs485_mode` have no effect.
- R7: A high `clr_read` or `tx_write` clears the pending request at the next clock edge. An event detected in the same cycle wins, and the request stays set.
- R8: `irq` equals the pending request gated by `irq_en`. An event latched while `irq_en` is low appears as soon as `irq_en` rises.
- R9: A `trig_level` of 0 never produces a below-trigger event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode | input | 1 | 1 = FIFO mode, 0 = single holding register |
| tx_count | input | CNT_W | Bytes currently held in the transmit path |
| trig_level | input | TRIG_W | Programmed below-trigger level |
| shift_busy | input | 1 | Serializer is still shifting a character |
| rs485_mode | input | 1 | Half-duplex driver mode: delay empty event until serializer idle |
| irq_en | input | 1 | Transmit-ready interrupt enable |
| clr_read | input | 1 | Status read while this source is the highest pending one |
| tx_write | input | 1 | Byte written into the transmit path |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives the FIFO level down through the trigger and then to empty, clearing in between. A design that merged the two events into one, or that re-fired while the level stayed low, would show the wrong pulse count. It holds the FIFO empty while the serializer is busy in driver mode, and it also holds the holding register empty with the serializer busy outside FIFO mode. An early empty event, or a wrongly applied delay, would be caught there. It also covers:

- an event that lands in the same cycle as a clear, which a design with the wrong priority would lose;
- a trigger level of zero, which a signed or inclusive compare would turn into a spurious event;
- an event latched while masked, which must survive until the enable rises.

// File: rtl/uart_txrdy_pkg.sv
package uart_txrdy_pkg;

    // Below-trigger detector state
    typedef struct packed {
        logic armed;
    } thresh_state_t;

    // Empty detector state
    typedef struct packed {
        logic armed;
    } empty_state_t;

    // Request latch state
    typedef struct packed {
        logic pending;
    } req_state_t;

endpackage

// File: rtl/uart_txrdy_thresh.sv
module uart_txrdy_thresh
    import uart_txrdy_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int TRIG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_mode,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [TRIG_W-1:0] trig_level,
    output logic              ev_below
);
    localparam int CMP_W = (CNT_W > TRIG_W) ? CNT_W : TRIG_W;

    thresh_state_t st_d, st_q;
    logic [CMP_W-1:0] cnt_ext;
    logic [CMP_W-1:0] trig_ext;
    logic             below;

    always_comb begin
        cnt_ext  = CMP_W'(tx_count);
        trig_ext = CMP_W'(trig_level);
        below    = cnt_ext < trig_ext;
        ev_below = fifo_mode && st_q.armed && below;
        st_d     = st_q;
        if (!fifo_mode) begin
            // Outside FIFO mode the crossing has no meaning
            st_d.armed = 1'b0;
        end else if (!below) begin
            st_d.armed = 1'b1;
        end else if (ev_below) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{armed: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/uart_txrdy_empty.sv
module uart_txrdy_empty
    import uart_txrdy_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_mode,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             shift_busy,
    input  logic             rs485_mode,
    input  logic             tx_write,
    output logic             ev_empty
);
    empty_state_t st_d, st_q;
    logic         drained;
    logic         wait_serial;

    always_comb begin
        wait_serial = fifo_mode && rs485_mode;
        drained     = (tx_count == '0) && (!wait_serial || !shift_busy);
        ev_empty    = st_q.armed && drained && !tx_write;
        st_d        = st_q;
        if (tx_write) begin
            st_d.armed = 1'b1;
        end else if (ev_empty) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            // Idle transmit path after reset counts as one empty event
            st_q <= '{armed: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/uart_txrdy_irq.sv
module uart_txrdy_irq
    import uart_txrdy_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int TRIG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_mode,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [TRIG_W-1:0] trig_level,
    input  logic              shift_busy,
    input  logic              rs485_mode,
    input  logic              irq_en,
    input  logic              clr_read,
    input  logic              tx_write,
    output logic              irq
);
    logic       ev_below;
    logic       ev_empty;
    logic       clear_req;
    req_state_t st_d, st_q;

    uart_txrdy_thresh #(
        .CNT_W (CNT_W),
        .TRIG_W(TRIG_W)
    ) u_thresh (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_mode (fifo_mode),
        .tx_count  (tx_count),
        .trig_level(trig_level),
        .ev_below  (ev_below)
    );

    uart_txrdy_empty #(
        .CNT_W(CNT_W)
    ) u_empty (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_mode (fifo_mode),
        .tx_count  (tx_count),
        .shift_busy(shift_busy),
        .rs485_mode(rs485_mode),
        .tx_write  (tx_write),
        .ev_empty  (ev_empty)
    );

    always_comb begin
        clear_req = clr_read || tx_write;
        st_d      = st_q;
        if (ev_below || ev_empty) begin
            st_d.pending = 1'b1;
        end else if (clear_req) begin
            st_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pending: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.pending && irq_en;
endmodule

// File: rtl/uart_txrdy_irq_chk.sv
module uart_txrdy_irq_chk #(
    parameter int TRIG_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_mode,
    input logic              rs485_mode,
    input logic              shift_busy,
    input logic [TRIG_W-1:0] trig_level,
    input logic              irq_en,
    input logic              clr_read,
    input logic              tx_write,
    input logic              ev_below,
    input logic              ev_empty,
    input logic              pending
);
    p_nonfifo_no_below_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode |-> !ev_below);

    p_below_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_below |=> pending);

    p_empty_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_empty |=> pending);

    p_empty_waits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode && rs485_mode && shift_busy) |-> !ev_empty);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_read || tx_write) && !ev_below && !ev_empty) |=> !pending);

    p_masked_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en && pending && !clr_read && !tx_write) |=> pending);

    p_trig_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_level == '0) |-> !ev_below);
endmodule

bind uart_txrdy_irq uart_txrdy_irq_chk #(.TRIG_W(TRIG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_mode (fifo_mode),
    .rs485_mode(rs485_mode),
    .shift_busy(shift_busy),
    .trig_level(trig_level),
    .irq_en    (irq_en),
    .clr_read  (clr_read),
    .tx_write  (tx_write),
    .ev_below  (ev_below),
    .ev_empty  (ev_empty),
    .pending   (st_q.pending)
);

// File: tb/uart_txrdy_irq_tb.sv
module uart_txrdy_irq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 36;

    typedef struct packed {
        logic       fm;
        logic [7:0] cnt;
        logic [7:0] trig;
        logic       busy;
        logic       rs;
        logic       en;
        logic       rd;
        logic       wr;
        logic       exp;
        logic [3:0] req;
    } vec_t;

    // fm, cnt, trig, busy, rs, en, rd, wr, expected irq, requirement
    localparam vec_t VEC [0:NVEC-1] = '{
        '{1'b0, 8'd0,  8'd8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd1}, // R1 idle empty
        '{1'b0, 8'd0,  8'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8}, // R8 masked
        '{1'b0, 8'd0,  8'd8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd8}, // R8 kept
        '{1'b0, 8'd0,  8'd8, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd7}, // R7 read clears
        '{1'b0, 8'd0,  8'd8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd7}, // R7 write
        '{1'b0, 8'd1,  8'd8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2}, // R2 full
        '{1'b0, 8'd0,  8'd8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2}, // R2 empty
        '{1'b0, 8'd0,  8'd8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd7}, // R7 write clears
        '{1'b0, 8'd1,  8'd8, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6}, // R6
        '{1'b0, 8'd0,  8'd8, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd6}, // R6 busy ignored
        '{1'b0, 8'd0,  8'd8, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd7},
        '{1'b1, 8'd0,  8'd8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd3}, // R3 no event
        '{1'b1, 8'd10, 8'd8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3}, // R3 arm
        '{1'b1, 8'd9,  8'd8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3},
        '{1'b1, 8'd7,  8'd8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd3}, // R3 fire
        '{1'b1, 8'd5,  8'd8, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd7},
        '{1'b1, 8'd3,  8'd8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd5}, // R5 no refire
        '{1'b1, 8'd0,  8'd8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd4}, // R4 second
        '{1'b1, 8'd0,  8'd8, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd7},
        '{1'b1, 8'd0,  8'd8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd5}, // R5 empty once
        '{1'b1, 8'd0,  8'd8, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd6},
        '{1'b1, 8'd2,  8'd8, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6},
        '{1'b1, 8'd0,  8'd8, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6}, // R6 held
        '{1'b1, 8'd0,  8'd8, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd6}, // R6 release
        '{1'b1, 8'd0,  8'd8, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd7},
        '{1'b1, 8'd9,  8'd8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd5}, // R5 re-arm
        '{1'b1, 8'd4,  8'd8, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd7}, // R7 event wins
        '{1'b1, 8'd4,  8'd8, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd7},
        '{1'b1, 8'd5,  8'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd9}, // R9
        '{1'b1, 8'd1,  8'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd9},
        '{1'b1, 8'd0,  8'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd9},
        '{1'b1, 8'd8,  8'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},
        '{1'b1, 8'd7,  8'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8}, // R8 latched masked
        '{1'b1, 8'd7,  8'd8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd8}, // R8 appears
        '{1'b1, 8'd7,  8'd8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd7},
        '{1'b1, 8'd7,  8'd8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_mode = 1'b0;
    logic [7:0] tx_count = 8'd0;
    logic [7:0] trig_level = 8'd8;
    logic       shift_busy = 1'b0;
    logic       rs485_mode = 1'b0;
    logic       irq_en = 1'b0;
    logic       clr_read = 1'b0;
    logic       tx_write = 1'b0;
    logic       irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_txrdy_irq #(.CNT_W(8), .TRIG_W(8)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_mode (fifo_mode),
        .tx_count  (tx_count),
        .trig_level(trig_level),
        .shift_busy(shift_busy),
        .rs485_mode(rs485_mode),
        .irq_en    (irq_en),
        .clr_read  (clr_read),
        .tx_write  (tx_write),
        .irq       (irq)
    );

    task automatic check(input logic exp, input int req, input string what);
        n_checks++;
        if (irq !== exp) begin
            n_fails++;
            $display("FAIL R%0d %s: irq=%b expected %b", req, what, irq, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        fifo_mode  = v.fm;
        tx_count   = v.cnt;
        trig_level = v.trig;
        shift_busy = v.busy;
        rs485_mode = v.rs;
        irq_en     = v.en;
        clr_read   = v.rd;
        tx_write   = v.wr;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state with enable high
        irq_en = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check(1'b0, 1, "during reset");
        @(negedge clk);
        rst_n = 1'b1;
        irq_en = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i]);
            check(VEC[i].exp, int'(VEC[i].req), $sformatf("vector %0d", i));
        end

        // R1: reset in mid-run clears pending, then idle empty re-raises it
        @(negedge clk);
        fifo_mode = 1'b0; tx_count = 8'd0; clr_read = 1'b0; tx_write = 1'b0;
        irq_en = 1'b1; rst_n = 1'b0;
        #1;
        check(1'b0, 1, "mid-run reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(1'b1, 1, "first edge after reset");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule